// File: doc/BRIEF.md
# Scaled Fixed-Point Timestamp Counter

This block produces a free-running 64-bit timestamp for downstream timers, all on one reference clock. The count is kept inside a wider fixed-point accumulator with 64 integer bits and 24 fraction bits. A programmable 32-bit increment is added on every enabled clock, so the visible count can advance by a fractional amount per tick. With scaling off, the count advances by exactly one per tick.

The block has no register decoder of its own. A separate decoder drives three write strobes:
- a control strobe that loads the enable and scale-enable bits;
- a scale strobe that loads the increment;
- a count strobe that replaces either 32-bit half of the visible count.

Software may rewrite a half while the counter runs. The 64-bit count and the current control state are outputs.

Top module: `sys_cnt_top`

## Requirements
- R1: After reset, `count_o` is 0, `en_o` and `scale_en_o` are 0, and `scale_o` is 0x01000000 (an increment of 1.0 with 24 fraction bits).
- R2: When `en_o` and `scale_en_o` are both 1, every clock edge adds the zero-extended `scale_o` to the 88-bit accumulator. `count_o` is the upper 64 bits of that accumulator. For example, a scale of 0x00800000 gives one count every two ticks, and 0x01800000 gives three counts every two ticks.
- R3: When `en_o` is 1 and `scale_en_o` is 0, `count_o` increases by exactly 1 per clock edge, whatever the value of `scale_o`.
- R4: While `en_o` is 0 and no count write is made, `count_o` holds its value.
- R5: A count write with `cnt_hi_i`=0 replaces bits 31:0 of the count with `cnt_d_i` and leaves bits 63:32 unchanged.
- R6: A count write with `cnt_hi_i`=1 replaces bits 63:32 of the count with `cnt_d_i` and leaves bits 31:0 unchanged.
- R7: A count write clears the 24 fraction bits. In the same cycle it overrides any increment, so no increment is applied on that edge.
- R8: The count wraps modulo 2^64, from 0xFFFFFFFF_FFFFFFFF to 0.
- R9: A control write or a scale write is visible on `en_o`/`scale_en_o` or `scale_o` after the clock edge on which it is made. The first increment under a new control value happens one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Load the control bits |
| ctrl_en_d_i | input | 1 | New enable bit |
| ctrl_sc_d_i | input | 1 | New scale-enable bit |
| scale_we_i | input | 1 | Load the scale increment |
| scale_d_i | input | 32 | New scale increment (8.24 fixed point) |
| cnt_we_i | input | 1 | Write one half of the count |
| cnt_hi_i | input | 1 | 1 selects the upper half, 0 selects the lower half |
| cnt_d_i | input | 32 | New value for the selected half |
| count_o | output | 64 | Visible count |
| en_o | output | 1 | Current enable bit |
| scale_en_o | output | 1 | Current scale-enable bit |
| scale_o | output | 32 | Current scale increment |

## Verification
Every write lands in a register on the clock edge on which its strobe is high, so `scale_o`, `en_o`, `scale_en_o` and a written count half are already visible after that same edge. An increment depends on the registered enable, so the first advance after enabling comes one edge later, and the edge that clears the enable still applies an increment. The bench drives strobes for one cycle at a time between falling edges and samples on the falling edge after the edge of interest. It enables the counter for exactly n edges by issuing the disable write n edges after the enable write, which makes the expected count an exact function of n and the scale.

// File: rtl/sys_cnt_pkg.sv
package sys_cnt_pkg;
  localparam int CNT_W  = 64;
  localparam int FRAC_W = 24;
  localparam int INC_W  = 32;

  typedef struct packed {
    logic en;
    logic scale_en;
  } ctrl_t;
endpackage

// File: rtl/sys_cnt_ctrl.sv
module sys_cnt_ctrl
  import sys_cnt_pkg::*;
#(
  parameter int INC_W_P   = INC_W,
  parameter int FRAC_W_P  = FRAC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  ctrl_t              ctrl_d_i,
  input  logic               scale_we_i,
  input  logic [INC_W_P-1:0] scale_d_i,
  output ctrl_t              ctrl_q_o,
  output logic [INC_W_P-1:0] scale_q_o
);
  localparam logic [INC_W_P-1:0] SCALE_RST = INC_W_P'(1) << FRAC_W_P;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o  <= '0;
      scale_q_o <= SCALE_RST;
    end else begin
      if (ctrl_we_i)  ctrl_q_o  <= ctrl_d_i;
      if (scale_we_i) scale_q_o <= scale_d_i;
    end
  end

  a_r9_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_q_o == $past(ctrl_d_i));
  a_r9_scale_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_we_i |=> scale_q_o == $past(scale_d_i));
endmodule

// File: rtl/sys_cnt_step.sv
module sys_cnt_step
  import sys_cnt_pkg::*;
#(
  parameter int ACC_W_P  = CNT_W + FRAC_W,
  parameter int INC_W_P  = INC_W,
  parameter int FRAC_W_P = FRAC_W
) (
  input  logic               scale_en_i,
  input  logic [INC_W_P-1:0] scale_i,
  output logic [ACC_W_P-1:0] inc_o
);
  localparam logic [ACC_W_P-1:0] UNIT = ACC_W_P'(1) << FRAC_W_P;

  // unscaled mode steps the integer part by one
  always_comb begin
    if (scale_en_i) inc_o = {{(ACC_W_P-INC_W_P){1'b0}}, scale_i};
    else            inc_o = UNIT;
  end
endmodule

// File: rtl/sys_cnt_accum.sv
module sys_cnt_accum
  import sys_cnt_pkg::*;
#(
  parameter int CNT_W_P  = CNT_W,
  parameter int FRAC_W_P = FRAC_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [CNT_W_P+FRAC_W_P-1:0]   inc_i,
  input  logic                          wr_i,
  input  logic                          wr_hi_i,
  input  logic [CNT_W_P/2-1:0]          wr_d_i,
  output logic [CNT_W_P-1:0]            count_o
);
  localparam int ACC_W  = CNT_W_P + FRAC_W_P;
  localparam int HALF_W = CNT_W_P / 2;

  logic [ACC_W-1:0]   acc_q;
  logic [CNT_W_P-1:0] wr_cnt;

  assign count_o = acc_q[ACC_W-1:FRAC_W_P];

  always_comb begin
    if (wr_hi_i) wr_cnt = {wr_d_i, count_o[HALF_W-1:0]};
    else         wr_cnt = {count_o[CNT_W_P-1:HALF_W], wr_d_i};
  end

  // write wins over increment; fraction restarts at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (wr_i) acc_q <= {wr_cnt, {FRAC_W_P{1'b0}}};
    else if (en_i) acc_q <= acc_q + inc_i;
  end

  a_r2_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i) |=> acc_q == $past(acc_q) + $past(inc_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(count_o));
  a_r5_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_hi_i) |=> (count_o[HALF_W-1:0] == $past(wr_d_i)) &&
                           (count_o[CNT_W_P-1:HALF_W] == $past(count_o[CNT_W_P-1:HALF_W])));
  a_r6_high_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_hi_i) |=> (count_o[CNT_W_P-1:HALF_W] == $past(wr_d_i)) &&
                          (count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0])));
  a_r7_frac_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> acc_q[FRAC_W_P-1:0] == '0);
endmodule

// File: rtl/sys_cnt_top.sv
module sys_cnt_top
  import sys_cnt_pkg::*;
#(
  parameter int CNT_W_P  = CNT_W,
  parameter int FRAC_W_P = FRAC_W,
  parameter int INC_W_P  = INC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_we_i,
  input  logic                 ctrl_en_d_i,
  input  logic                 ctrl_sc_d_i,
  input  logic                 scale_we_i,
  input  logic [INC_W_P-1:0]   scale_d_i,
  input  logic                 cnt_we_i,
  input  logic                 cnt_hi_i,
  input  logic [CNT_W_P/2-1:0] cnt_d_i,
  output logic [CNT_W_P-1:0]   count_o,
  output logic                 en_o,
  output logic                 scale_en_o,
  output logic [INC_W_P-1:0]   scale_o
);
  localparam int ACC_W = CNT_W_P + FRAC_W_P;

  ctrl_t            ctrl_d, ctrl_q;
  logic [ACC_W-1:0] inc;

  assign ctrl_d.en       = ctrl_en_d_i;
  assign ctrl_d.scale_en = ctrl_sc_d_i;
  assign en_o            = ctrl_q.en;
  assign scale_en_o      = ctrl_q.scale_en;

  sys_cnt_ctrl #(.INC_W_P(INC_W_P), .FRAC_W_P(FRAC_W_P)) u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i, .ctrl_d_i(ctrl_d),
    .scale_we_i, .scale_d_i,
    .ctrl_q_o(ctrl_q), .scale_q_o(scale_o)
  );

  sys_cnt_step #(.ACC_W_P(ACC_W), .INC_W_P(INC_W_P), .FRAC_W_P(FRAC_W_P)) u_step (
    .scale_en_i(ctrl_q.scale_en), .scale_i(scale_o), .inc_o(inc)
  );

  sys_cnt_accum #(.CNT_W_P(CNT_W_P), .FRAC_W_P(FRAC_W_P)) u_accum (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.en), .inc_i(inc),
    .wr_i(cnt_we_i), .wr_hi_i(cnt_hi_i), .wr_d_i(cnt_d_i),
    .count_o
  );

  a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !scale_en_o && !cnt_we_i) |=> count_o == $past(count_o) + 1'b1);
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !scale_en_o && !cnt_we_i && (&count_o)) |=> count_o == '0);
endmodule

// File: tb/sys_cnt_top_bench.sv
module sys_cnt_top_bench;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, ctrl_en_d = 1'b0, ctrl_sc_d = 1'b0;
  logic        scale_we = 1'b0;
  logic [31:0] scale_d = '0;
  logic        cnt_we = 1'b0, cnt_hi = 1'b0;
  logic [31:0] cnt_d = '0;
  logic [63:0] count;
  logic        en, scale_en;
  logic [31:0] scale;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sys_cnt_top u_sys_cnt_top (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_en_d_i(ctrl_en_d), .ctrl_sc_d_i(ctrl_sc_d),
    .scale_we_i(scale_we), .scale_d_i(scale_d),
    .cnt_we_i(cnt_we), .cnt_hi_i(cnt_hi), .cnt_d_i(cnt_d),
    .count_o(count), .en_o(en), .scale_en_o(scale_en), .scale_o(scale)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(bit e, bit s);
    ctrl_we = 1'b1; ctrl_en_d = e; ctrl_sc_d = s;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_scale(logic [31:0] v);
    scale_we = 1'b1; scale_d = v;
    @(negedge clk);
    scale_we = 1'b0;
  endtask

  task automatic wr_cnt(bit hi, logic [31:0] v);
    cnt_we = 1'b1; cnt_hi = hi; cnt_d = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // exactly n increments: enable edge, n-1 idle edges, disable edge
  task automatic run(bit s, int n);
    wr_ctrl(1'b1, s);
    repeat (n-1) @(negedge clk);
    wr_ctrl(1'b0, s);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 64'd0);
    chk("R1 en", {63'd0, en}, 64'd0);
    chk("R1 scale_en", {63'd0, scale_en}, 64'd0);
    chk("R1 scale", {32'd0, scale}, 64'h0100_0000);
  endtask

  task automatic t_ctrl_timing;
    wr_scale(32'h0080_0000);
    chk("R9 scale", {32'd0, scale}, 64'h0080_0000);
    wr_ctrl(1'b1, 1'b0);
    chk("R9 en", {63'd0, en}, 64'd1);
    chk("R9 no step on enable edge", count, 64'd0);
    wr_ctrl(1'b0, 1'b0);
    chk("R9 one step after", count, 64'd1);
    wr_cnt(1'b0, 32'd0);
  endtask

  task automatic t_scaled;
    wr_scale(32'h0080_0000);
    run(1'b1, 7);
    chk("R2 half rate", count, 64'd3);
    wr_cnt(1'b0, 32'd0);
    wr_scale(32'h0180_0000);
    run(1'b1, 4);
    chk("R2 1.5 rate", count, 64'd6);
  endtask

  task automatic t_unscaled;
    wr_cnt(1'b0, 32'd100);
    wr_scale(32'h0500_0000);
    run(1'b0, 5);
    chk("R3 unit step", count, 64'd105);
  endtask

  task automatic t_hold;
    repeat (10) @(negedge clk);
    chk("R4 hold", count, 64'd105);
  endtask

  task automatic t_halves;
    wr_cnt(1'b1, 32'hdead_beef);
    chk("R6 high half", count, 64'hdead_beef_0000_0069);
    wr_cnt(1'b0, 32'h1234_5678);
    chk("R5 low half", count, 64'hdead_beef_1234_5678);
  endtask

  task automatic t_frac_priority;
    wr_cnt(1'b0, 32'd10);
    wr_cnt(1'b1, 32'd0);
    wr_scale(32'h0080_0000);
    run(1'b1, 1);
    wr_cnt(1'b0, 32'd10);
    run(1'b1, 1);
    chk("R7 fraction cleared", count, 64'd10);
    wr_ctrl(1'b1, 1'b0);
    wr_cnt(1'b0, 32'd50);
    chk("R7 write beats step", count, 64'd50);
    @(negedge clk);
    chk("R7 step resumes", count, 64'd51);
    wr_ctrl(1'b0, 1'b0);
  endtask

  task automatic t_wrap;
    wr_cnt(1'b1, 32'hffff_ffff);
    wr_cnt(1'b0, 32'hffff_fffe);
    run(1'b0, 3);
    chk("R8 wrap", count, 64'd1);
  endtask

  initial begin
    #(PERIOD*50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_timing();
    t_scaled();
    t_unscaled();
    t_hold();
    t_halves();
    t_frac_priority();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule